// File: doc/BRIEF.md
# Converter reset and power-down sequencer

This block decides when the conversion core of a stereo converter may run. It watches three things: a power-good indication, an active-low request pin, and a one-cycle sample tick derived from the system clock. While the supplies are bad or the pin is low, it holds the core in reset and forces the digital output to zero. Once both conditions clear, it lets the core go at the next sample tick. It then keeps the output forced to zero for a fixed number of sample periods while the filters settle, and only after that marks the data as valid.

The same pin also selects power-down. A short low pulse only restarts the core. If the pin stays low for a whole counted window of sample ticks, the block enters power-down. Raising the pin from power-down runs the ordinary release and settle sequence.

The pin goes through a synchronizer of `SYNC_STAGES` flops that are cleared to low. An unconnected pin, which the board pull-down holds low, therefore reads as a reset request. Power-good acts as an asynchronous clear of the whole block.

States and transitions:
- HOLD: core in reset. HOLD→ARM when the synchronized pin is high. HOLD→SLEEP on the `PDOWN_TICKS`-th tick counted in HOLD.
- ARM: core still in reset, waiting for the sample-tick boundary. ARM→SETTLE on a tick. ARM→HOLD when the pin is low.
- SETTLE: core running, output still forced to zero. SETTLE→RUN on the `SETTLE_TICKS`-th tick counted in SETTLE. SETTLE→HOLD when the pin is low.
- RUN: output valid. RUN→HOLD when the pin is low.
- SLEEP: power-down. SLEEP→ARM when the pin is high.
- From every state, power-good low returns the block to HOLD at once and clears the counter.

Top module: `conv_rst_seq`

## Requirements
- R1: The pin `rst_req_n` passes through `SYNC_STAGES` flops. After a high-to-low change that is stable across the clock edges, `core_rst` rises on the edge `SYNC_STAGES`+1 clocks later, and `out_valid` falls on that same edge. A pin that has never been driven high reads as low.
- R2: While `pwr_good` is low, the outputs are `core_rst`=1, `pdown`=0, `out_valid`=0 and `force_zero`=1, whatever the pin does. They take these values asynchronously, within the same clock cycle in which `pwr_good` falls.
- R3: With `pwr_good` high and the synchronized pin high, `core_rst` falls on the first clock edge at which `fs_tick` is 1. This is no later than one sample period after the synchronizer has passed the high level.
- R4: `out_valid` rises on the edge that carries the `SETTLE_TICKS`-th `fs_tick` after the edge on which `core_rst` fell. Until then `force_zero` is 1. At all times `force_zero` is the inverse of `out_valid`.
- R5: In the held-reset state, ticks are counted starting after the edge that entered that state. `pdown` rises on the edge of the `PDOWN_TICKS`-th such tick. `pdown` never rises while `out_valid` is 1.
- R6: From power-down, a high synchronized pin clears `pdown` on the edge `SYNC_STAGES`+1 clocks after the pin rises, while `core_rst` stays 1. After that, the R3 release and the R4 settle count follow.
- R7: If the pin returns high before the power-down count completes, the count is cleared. A later low period must count all `PDOWN_TICKS` ticks again before `pdown` rises.
- R8: A low pulse on the pin of a single clock period, taken during RUN, moves the block to the held-reset state. The block then runs a full release and settle sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sequencing runs on it |
| pwr_good | input | 1 | Supplies good; low clears the block asynchronously |
| rst_req_n | input | 1 | Asynchronous active-low reset / power-down request pin |
| fs_tick | input | 1 | One-clock pulse per sample period |
| core_rst | output | 1 | Holds the conversion core in reset when 1 |
| pdown | output | 1 | Power-down state active |
| out_valid | output | 1 | Converted data may be used |
| force_zero | output | 1 | Digital output must be forced to zero |

## Verification
The bench runs the whole sequence at sample-tick spacings of one to four clocks. At each spacing it counts the exact ticks between the release of `core_rst` and the rise of `out_valid`, so a settle counter that is off by one, or that also counts the release tick, shows up as a miscount. It measures the power-down window twice: once from a fresh entry, and once after an earlier partial low period. A counter that kept stale ticks would sleep early in the second case. The bench also times the synchronizer latency to the cycle, fires a single-clock low pulse during RUN that a missing stage or a level filter would swallow, and drops power-good both during RUN and during power-down to check that all outputs clear without waiting for an edge.

// File: rtl/conv_rst_seq_pkg.sv
package conv_rst_seq_pkg;
    typedef enum logic [2:0] {
        SQ_HOLD   = 3'd0,
        SQ_ARM    = 3'd1,
        SQ_SETTLE = 3'd2,
        SQ_RUN    = 3'd3,
        SQ_SLEEP  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    chain[i] <= 1'b0;
                end else begin
                    chain[i] <= (i == 0) ? din : chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/crs_tick_cnt.sv
module crs_tick_cnt #(
    parameter int WIDTH = 17
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/crs_fsm.sv
module crs_fsm
    import conv_rst_seq_pkg::*;
#(
    parameter int SETTLE_TICKS = 1116,
    parameter int PDOWN_TICKS  = 65536,
    parameter int CNT_W        = 17
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             pin_hi,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             core_rst,
    output logic             pdown,
    output logic             out_valid,
    output logic             force_zero
);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_TICKS - 1);
    localparam logic [CNT_W-1:0] PDOWN_LAST  = CNT_W'(PDOWN_TICKS - 1);

    seq_state_t state, state_d;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state <= SQ_HOLD;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            SQ_HOLD: begin
                if (pin_hi) begin
                    state_d = SQ_ARM;
                end else if (tick && count == PDOWN_LAST) begin
                    state_d = SQ_SLEEP;
                end
            end
            SQ_ARM: begin
                if (!pin_hi) begin
                    state_d = SQ_HOLD;
                end else if (tick) begin
                    state_d = SQ_SETTLE;
                end
            end
            SQ_SETTLE: begin
                if (!pin_hi) begin
                    state_d = SQ_HOLD;
                end else if (tick && count == SETTLE_LAST) begin
                    state_d = SQ_RUN;
                end
            end
            SQ_RUN: begin
                if (!pin_hi) begin
                    state_d = SQ_HOLD;
                end
            end
            SQ_SLEEP: begin
                if (pin_hi) begin
                    state_d = SQ_ARM;
                end
            end
            default: state_d = SQ_HOLD;
        endcase
    end

    always_comb begin
        cnt_clr    = (state_d != state);
        cnt_inc    = tick && (state == SQ_HOLD || state == SQ_SETTLE);
        core_rst   = (state == SQ_HOLD) || (state == SQ_ARM) || (state == SQ_SLEEP);
        pdown      = (state == SQ_SLEEP);
        out_valid  = (state == SQ_RUN);
        force_zero = (state != SQ_RUN);
    end
endmodule

// File: rtl/conv_rst_seq.sv
module conv_rst_seq #(
    parameter int SETTLE_TICKS = 1116,
    parameter int PDOWN_TICKS  = 65536,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic rst_req_n,
    input  logic fs_tick,
    output logic core_rst,
    output logic pdown,
    output logic out_valid,
    output logic force_zero
);
    localparam int MAX_TICKS = (PDOWN_TICKS > SETTLE_TICKS) ? PDOWN_TICKS : SETTLE_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic             rst_sync;
    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] count;

    crs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .arst_n(pwr_good),
        .din   (rst_req_n),
        .dout  (rst_sync)
    );

    crs_tick_cnt #(.WIDTH(CNT_W)) u_cnt (
        .clk   (clk),
        .arst_n(pwr_good),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (count)
    );

    crs_fsm #(
        .SETTLE_TICKS(SETTLE_TICKS),
        .PDOWN_TICKS (PDOWN_TICKS),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .arst_n    (pwr_good),
        .pin_hi    (rst_sync),
        .tick      (fs_tick),
        .count     (count),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .core_rst  (core_rst),
        .pdown     (pdown),
        .out_valid (out_valid),
        .force_zero(force_zero)
    );
endmodule

// File: rtl/conv_rst_seq_chk.sv
module conv_rst_seq_chk (
    input logic clk,
    input logic pwr_good,
    input logic rst_sync,
    input logic fs_tick,
    input logic core_rst,
    input logic pdown,
    input logic out_valid
);
    p_pin_low_resets_r1: assert property (@(posedge clk) disable iff (!pwr_good)
        !rst_sync |=> core_rst);

    p_release_on_tick_r3: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(core_rst) |-> ($past(fs_tick) && $past(rst_sync)));

    p_valid_after_settle_r4: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(out_valid) |-> ($past(fs_tick) && !$past(core_rst)));

    p_sleep_from_hold_r5: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(pdown) |-> ($past(fs_tick) && !$past(rst_sync) && !$past(out_valid)));

    p_wake_to_arm_r6: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(pdown) |-> (core_rst && $past(rst_sync)));
endmodule

bind conv_rst_seq conv_rst_seq_chk u_chk (
    .clk      (clk),
    .pwr_good (pwr_good),
    .rst_sync (rst_sync),
    .fs_tick  (fs_tick),
    .core_rst (core_rst),
    .pdown    (pdown),
    .out_valid(out_valid)
);

// File: tb/conv_rst_seq_test.sv
module conv_rst_seq_test;
    localparam int SETTLE = 12;
    localparam int PDN    = 20;
    localparam int SYN    = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic pwr_good  = 1'b0;
    logic rst_req_n = 1'b0;
    logic fs_tick   = 1'b0;
    logic core_rst, pdown, out_valid, force_zero;

    int tick_period = 1;
    int div = 0;
    int ticks = 0;
    int vectors = 0;
    int errors = 0;
    int cyc = 0;

    conv_rst_seq #(.SETTLE_TICKS(SETTLE), .PDOWN_TICKS(PDN), .SYNC_STAGES(SYN)) uut (
        .clk(clk), .pwr_good(pwr_good), .rst_req_n(rst_req_n), .fs_tick(fs_tick),
        .core_rst(core_rst), .pdown(pdown), .out_valid(out_valid), .force_zero(force_zero)
    );

    always @(negedge clk) begin
        if (div >= tick_period - 1) begin
            fs_tick <= 1'b1;
            div     <= 0;
        end else begin
            fs_tick <= 1'b0;
            div     <= div + 1;
        end
    end

    always @(posedge clk) begin
        if (fs_tick) ticks <= ticks + 1;
        cyc <= cyc + 1;
        if (cyc > 60000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 60000);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic sample();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_release(input int bound);
        int c = 0;
        int prev = ticks;
        while (core_rst && c <= bound) begin
            prev = ticks;
            sample();
            c++;
        end
        chk("R3 release within bound", int'(c <= bound), 1);
        chk("R3 release on tick edge", ticks - prev, 1);
    endtask

    task automatic settle_check(input string req);
        int base = ticks;
        int c = 0;
        while (!out_valid && c < 1000) begin
            if (!force_zero || (ticks - base) >= SETTLE) begin
                chk({req, " early/zero"}, ticks - base, SETTLE - 1);
            end
            sample();
            c++;
        end
        chk({req, " settle ticks"}, ticks - base, SETTLE);
        chk({req, " force_zero off"}, int'(force_zero), 0);
    endtask

    task automatic pdown_check(input string req);
        int base = ticks;
        int c = 0;
        while (!pdown && c < 1000) begin
            if ((ticks - base) > PDN) break;
            sample();
            c++;
        end
        chk({req, " pdown ticks"}, ticks - base, PDN);
        chk({req, " no valid in sleep"}, int'(out_valid), 0);
    endtask

    initial begin
        for (int tp = 1; tp <= 4; tp++) begin
            tick_period = tp;
            pwr_good  = 1'b0;
            rst_req_n = 1'b0;
            repeat (3) sample();
            chk("R2 reset core_rst", int'(core_rst), 1);
            chk("R2 reset pdown", int'(pdown), 0);
            chk("R2 reset out_valid", int'(out_valid), 0);
            chk("R2 reset force_zero", int'(force_zero), 1);
            rst_req_n = 1'b1;
            repeat (4) sample();
            chk("R2 held while power bad", int'(core_rst), 1);

            pwr_good = 1'b1;
            wait_release(SYN + 2 + tp);
            settle_check("R4");

            // R1: exact synchronizer latency from RUN
            rst_req_n = 1'b0;
            repeat (SYN) sample();
            chk("R1 not yet reset", int'(core_rst), 0);
            sample();
            chk("R1 reset after sync", int'(core_rst), 1);
            chk("R1 valid dropped", int'(out_valid), 0);

            // R7: partial low period, then a fresh full window
            begin
                int base = ticks;
                int c = 0;
                while ((ticks - base) < PDN / 2 && c < 1000) begin
                    sample();
                    c++;
                end
                chk("R7 no early sleep", int'(pdown), 0);
            end
            rst_req_n = 1'b1;
            wait_release(SYN + 2 + tp);
            rst_req_n = 1'b0;
            begin
                int c = 0;
                while (!core_rst && c < 100) begin
                    sample();
                    c++;
                end
            end
            pdown_check("R7/R5");

            // R6: wake from power-down
            rst_req_n = 1'b1;
            repeat (SYN) sample();
            chk("R6 still asleep", int'(pdown), 1);
            sample();
            chk("R6 pdown cleared", int'(pdown), 0);
            chk("R6 core held", int'(core_rst), 1);
            wait_release(SYN + 2 + tp);
            settle_check("R6");

            // R8: one-clock low pulse during RUN
            rst_req_n = 1'b0;
            sample();
            rst_req_n = 1'b1;
            sample();
            chk("R8 not yet reset", int'(core_rst), 0);
            sample();
            chk("R8 pulse caught", int'(core_rst), 1);
            wait_release(SYN + 2 + tp);
            settle_check("R8");

            // R2: asynchronous drop during RUN
            pwr_good = 1'b0;
            #1;
            chk("R2 async core_rst", int'(core_rst), 1);
            chk("R2 async out_valid", int'(out_valid), 0);
            chk("R2 async force_zero", int'(force_zero), 1);
            sample();
            pwr_good  = 1'b1;
            rst_req_n = 1'b0;
            begin
                int c = 0;
                while (!pdown && c < 1000) begin
                    sample();
                    c++;
                end
                chk("R5 sleep after power-up low pin", int'(pdown), 1);
            end
            pwr_good = 1'b0;
            #1;
            chk("R2 async pdown clear", int'(pdown), 0);
            chk("R2 async core_rst in sleep", int'(core_rst), 1);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule